// File: doc/BRIEF.md
# Packed Halfword Saturating ALU

This block performs lane-parallel arithmetic on two 64-bit operands. Each operand is split into four 16-bit lanes. Every lane is computed on its own and clamped to its target range, so a lane never wraps and never carries into a neighbour. It suits media and DSP datapaths that work on packed halfwords and need saturation rather than modular results.

The operations are signed add and subtract, add and subtract with an unsigned first operand and a signed second operand, a rounding average, and two scaled adds. The scaled adds shift the first operand left or right by 0 to 3 places and then add the second operand. A parameter selects whether the result is registered. When it is registered, a valid strobe travels with the data and the result is held between valid inputs.

Top module: `phsat_alu`

## Requirements
- R1: The four 16-bit lanes are independent: lane k of the result depends only on lane k of `a_i`, lane k of `b_i`, `op_i` and `shamt_i`. Lane k occupies bits [16k+15:16k].
- R2: Opcode 0 (signed add) and opcode 1 (signed subtract, a minus b) treat both lanes as two's complement and clamp the exact result to -32768..32767.
- R3: Opcode 2 (add) and opcode 3 (subtract, a minus b) treat the `a_i` lane as unsigned 0..65535 and the `b_i` lane as two's complement, and clamp the exact result to 0..65535.
- R4: Opcode 4 (average) adds both lanes as unsigned values into a 17-bit sum S. The lane result is S shifted right by one place, with bit 0 of S ORed into its least significant bit.
- R5: Opcode 5 multiplies the signed `a_i` lane by 2^`shamt_i`, adds the signed `b_i` lane, and clamps to -32768..32767. No wrap occurs before the clamp.
- R6: Opcode 6 shifts the signed `a_i` lane right arithmetically by `shamt_i` places, adds the signed `b_i` lane, and clamps to -32768..32767.
- R7: `shamt_i` is 2 bits wide, so every shift amount from 0 to 3 is legal and is applied exactly.
- R8: Opcode 7 is unused and gives an all-zero result, whatever the operands are.
- R9: With the output register present (the default), `result_o` and `valid_o` appear one clock after `valid_i` is high. `valid_o` is low otherwise, and `result_o` holds its last value while `valid_i` is low.
- R10: While `rst_ni` is low, `valid_o` is 0 and `result_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input operands and opcode are valid |
| op_i | input | 3 | Operation select, encodings in R2 to R8 |
| shamt_i | input | 2 | Shift amount for opcodes 5 and 6 |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| valid_o | output | 1 | Result is valid |
| result_o | output | 64 | Packed lane result |

## Verification
Each operation is driven with lanes that sit exactly on, just inside and just beyond the clamp limits. These show whether the clamp acts on the exact result or on a wrapped one. The mixed-sign forms are given a first operand above 32767 and a negative second operand, which separates unsigned handling from signed handling. The average is given odd and even sums, which separates the ORed rounding bit from plain truncation and from round-half-up. The scaled adds use a first operand whose shifted value leaves the 16-bit range while the final sum stays inside it, so saturating after the shift gives a different answer from wrapping the shift. A single changed lane shows that no other lane moves.

// File: rtl/phsat_pkg.sv
package phsat_pkg;
  typedef enum logic [2:0] {
    OP_ADD_SS  = 3'd0,
    OP_SUB_SS  = 3'd1,
    OP_ADD_US  = 3'd2,
    OP_SUB_US  = 3'd3,
    OP_AVG     = 3'd4,
    OP_SHL_ADD = 3'd5,
    OP_SHR_ADD = 3'd6,
    OP_NONE    = 3'd7
  } op_e;
endpackage

// File: rtl/phsat_clamp.sv
module phsat_clamp #(
  parameter int LANE_W = 16,
  parameter int EXT_W  = 20
) (
  input  logic signed [EXT_W-1:0]  val_i,
  input  logic                     uns_i,
  output logic        [LANE_W-1:0] res_o
);
  localparam logic signed [EXT_W-1:0] SMAX = EXT_W'((64'sd1 <<< (LANE_W-1)) - 64'sd1);
  localparam logic signed [EXT_W-1:0] SMIN = EXT_W'(-(64'sd1 <<< (LANE_W-1)));
  localparam logic signed [EXT_W-1:0] UMAX = EXT_W'((64'sd1 <<< LANE_W) - 64'sd1);
  localparam logic signed [EXT_W-1:0] ZERO = '0;

  always_comb begin
    if (uns_i) begin
      if (val_i < ZERO)      res_o = '0;
      else if (val_i > UMAX) res_o = '1;
      else                   res_o = val_i[LANE_W-1:0];
    end else begin
      if (val_i > SMAX)      res_o = {1'b0, {(LANE_W-1){1'b1}}};
      else if (val_i < SMIN) res_o = {1'b1, {(LANE_W-1){1'b0}}};
      else                   res_o = val_i[LANE_W-1:0];
    end
  end
endmodule

// File: rtl/phsat_lane.sv
module phsat_lane
  import phsat_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int SH_W   = 2,
  parameter int EXT_W  = LANE_W + (1 << SH_W)
) (
  input  op_e               op_i,
  input  logic [SH_W-1:0]   sh_i,
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [LANE_W-1:0] res_o
);
  localparam int PAD_W = EXT_W - LANE_W;

  logic signed [EXT_W-1:0] a_s, a_u, b_s, sum;
  logic                    uns;
  logic [LANE_W:0]         avg_sum;
  logic [LANE_W-1:0]       avg_res, sat_res;

  assign a_s = {{PAD_W{a_i[LANE_W-1]}}, a_i};
  assign a_u = {{PAD_W{1'b0}}, a_i};
  assign b_s = {{PAD_W{b_i[LANE_W-1]}}, b_i};

  // average: ORing the dropped bit is a sticky round
  assign avg_sum = {1'b0, a_i} + {1'b0, b_i};
  assign avg_res = avg_sum[LANE_W:1] | {{(LANE_W-1){1'b0}}, avg_sum[0]};

  always_comb begin
    uns = 1'b0;
    unique case (op_i)
      OP_ADD_SS:  sum = a_s + b_s;
      OP_SUB_SS:  sum = a_s - b_s;
      OP_ADD_US:  begin sum = a_u + b_s; uns = 1'b1; end
      OP_SUB_US:  begin sum = a_u - b_s; uns = 1'b1; end
      OP_SHL_ADD: sum = (a_s <<< sh_i) + b_s;
      OP_SHR_ADD: sum = (a_s >>> sh_i) + b_s;
      default:    sum = '0;
    endcase
  end

  phsat_clamp #(.LANE_W(LANE_W), .EXT_W(EXT_W)) u_clamp (
    .val_i(sum),
    .uns_i(uns),
    .res_o(sat_res)
  );

  always_comb begin
    unique case (op_i)
      OP_AVG:  res_o = avg_res;
      OP_NONE: res_o = '0;
      default: res_o = sat_res;
    endcase
  end
endmodule

// File: rtl/phsat_alu.sv
module phsat_alu
  import phsat_pkg::*;
#(
  parameter  int LANE_W    = 16,
  parameter  int NUM_LANES = 4,
  parameter  int SH_W      = 2,
  parameter  bit REG_OUT   = 1'b1,
  localparam int DATA_W    = LANE_W * NUM_LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int EXT_W = LANE_W + (1 << SH_W);

  op_e               op;
  logic [DATA_W-1:0] res_d;

  assign op = op_e'(op_i);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    phsat_lane #(.LANE_W(LANE_W), .SH_W(SH_W), .EXT_W(EXT_W)) u_lane (
      .op_i (op),
      .sh_i (shamt_i),
      .a_i  (a_i[l*LANE_W +: LANE_W]),
      .b_i  (b_i[l*LANE_W +: LANE_W]),
      .res_o(res_d[l*LANE_W +: LANE_W])
    );
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o  <= 1'b0;
        result_o <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) result_o <= res_d;
      end
    end
  end else begin : g_comb
    assign valid_o  = valid_i;
    assign result_o = res_d;
  end
endmodule

// File: rtl/phsat_alu_chk.sv
module phsat_alu_chk #(
  parameter  int LANE_W    = 16,
  parameter  int NUM_LANES = 4,
  parameter  int SH_W      = 2,
  parameter  bit REG_OUT   = 1'b1,
  localparam int DATA_W    = LANE_W * NUM_LANES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [SH_W-1:0]   shamt_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);
  logic [2:0]        c_op;
  logic [DATA_W-1:0] c_a, c_b;

  if (REG_OUT) begin : g_q
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        c_op <= '0;
        c_a  <= '0;
        c_b  <= '0;
      end else begin
        c_op <= op_i;
        c_a  <= a_i;
        c_b  <= b_i;
      end
    end

    a_r9_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == $past(valid_i));
    a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(valid_i) |-> $stable(result_o));
    a_r10_reset_idle: assert property (@(posedge clk_i)
      !rst_ni |-> (!valid_o && result_o == '0));
  end else begin : g_c
    assign c_op = op_i;
    assign c_a  = a_i;
    assign c_b  = b_i;
  end

  a_r8_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && c_op == 3'd7) |-> result_o == '0);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lchk
    logic [LANE_W-1:0] la, lb, lr;
    assign la = c_a[l*LANE_W +: LANE_W];
    assign lb = c_b[l*LANE_W +: LANE_W];
    assign lr = result_o[l*LANE_W +: LANE_W];

    a_r2_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && c_op == 3'd0 && !la[LANE_W-1] && !lb[LANE_W-1]) |-> !lr[LANE_W-1]);
    a_r3_sub_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && c_op == 3'd3 && !lb[LANE_W-1]) |-> lr <= la);
    a_r4_avg_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && c_op == 3'd4) |->
        (lr >= ((la < lb) ? la : lb) && lr <= ((la < lb) ? lb : la)));
  end
endmodule

bind phsat_alu phsat_alu_chk #(
  .LANE_W(LANE_W), .NUM_LANES(NUM_LANES), .SH_W(SH_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .shamt_i(shamt_i), .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .result_o(result_o)
);

// File: tb/phsat_alu_test.sv
module phsat_alu_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  shamt_i = '0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  phsat_alu uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .shamt_i(shamt_i), .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .result_o(result_o)
  );

  function automatic int sat_s(int v);
    return (v > 32767) ? 32767 : (v < -32768) ? -32768 : v;
  endfunction

  function automatic int sat_u(int v);
    return (v > 65535) ? 65535 : (v < 0) ? 0 : v;
  endfunction

  function automatic logic [15:0] ref_lane(int op, int sh, logic [15:0] a, logic [15:0] b);
    int sa, sb, ua, ub, r;
    sa = int'($signed(a)); sb = int'($signed(b));
    ua = int'(a);          ub = int'(b);
    case (op)
      0: r = sat_s(sa + sb);
      1: r = sat_s(sa - sb);
      2: r = sat_u(ua + sb);
      3: r = sat_u(ua - sb);
      4: r = ((ua + ub) >> 1) | ((ua + ub) & 1);
      5: r = sat_s((sa * (1 << sh)) + sb);
      6: r = sat_s((sa >>> sh) + sb);
      default: r = 0;
    endcase
    return r[15:0];
  endfunction

  function automatic logic [63:0] ref_word(int op, int sh, logic [63:0] a, logic [63:0] b);
    logic [63:0] w;
    for (int l = 0; l < 4; l++) w[l*16 +: 16] = ref_lane(op, sh, a[l*16 +: 16], b[l*16 +: 16]);
    return w;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one valid input, sample the registered result one cycle later
  task automatic run_op(int op, int sh, logic [63:0] a, logic [63:0] b);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = 3'(op); shamt_i = 2'(sh); a_i = a; b_i = b;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic op_check(string tag, int op, int sh, logic [63:0] a, logic [63:0] b,
                          logic [63:0] exp);
    run_op(op, sh, a, b);
    check({tag, " valid"}, {63'd0, valid_o}, 64'd1);
    check(tag, result_o, exp);
    check({tag, " model"}, result_o, ref_word(op, sh, a, b));
  endtask

  task automatic t_reset();
    check("R10 valid in reset", {63'd0, valid_o}, 64'd0);
    check("R10 result in reset", result_o, 64'd0);
  endtask

  task automatic t_signed();
    op_check("R2 add", 0, 0, 64'h0005_8000_8000_7fff, 64'hfffd_0001_ffff_0001,
             64'h0002_8001_8000_7fff);
    op_check("R2 sub", 1, 0, 64'h0005_0000_7fff_8000, 64'h0007_8000_ffff_0001,
             64'hfffe_7fff_7fff_8000);
  endtask

  task automatic t_unsigned();
    op_check("R3 add", 2, 0, 64'h1234_8000_0001_ffff, 64'h0001_7fff_fffe_0001,
             64'h1235_ffff_0000_ffff);
    op_check("R3 sub", 3, 0, 64'h0100_fff0_0005_9000, 64'h0100_ff00_0007_1000,
             64'h0000_ffff_0000_8000);
  endtask

  task automatic t_avg();
    op_check("R4 avg", 4, 0, 64'h0003_ffff_ffff_0001, 64'h0004_fffe_ffff_0002,
             64'h0003_ffff_ffff_0001);
    op_check("R4 avg even", 4, 0, 64'h0001_0000_0002_0100, 64'h0001_0000_0004_0300,
             64'h0001_0000_0003_0200);
  endtask

  task automatic t_shift();
    op_check("R5 shl sat after shift", 5, 3, 64'h0001_1000_c000_1000, 64'h0000_8000_0000_0000,
             64'h0008_0000_8000_7fff);
    op_check("R5 R7 shl by 2", 5, 2, 64'h0000_c000_0003_1000, 64'h0000_7fff_0004_0000,
             64'h0000_8000_0010_4000);
    op_check("R6 R7 shr by 3", 6, 3, 64'h0010_8000_ffff_7fff, 64'h0001_0001_0000_0000,
             64'h0003_f001_ffff_0fff);
    op_check("R6 R7 shr by 0", 6, 0, 64'h0000_7fff_8000_0007, 64'h0000_0001_ffff_0002,
             64'h0000_7fff_8000_0009);
    op_check("R6 R7 shr by 1", 6, 1, 64'h0000_0000_fffb_0007, 64'h0000_0000_0000_0002,
             64'h0000_0000_fffd_0005);
  endtask

  task automatic t_unused();
    op_check("R8 unused op", 7, 3, 64'hffff_1234_8000_7fff, 64'h0001_4321_8000_7fff, 64'h0);
  endtask

  task automatic t_hold();
    logic [63:0] keep;
    op_check("R9 latency", 0, 0, 64'h0001_0002_0003_0004, 64'h0010_0020_0030_0040,
             64'h0011_0022_0033_0044);
    keep = result_o;
    a_i = 64'hdead_beef_0bad_f00d; b_i = 64'h1111_2222_3333_4444; op_i = 3'd1;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R9 valid low when idle", {63'd0, valid_o}, 64'd0);
    check("R9 result held when idle", result_o, keep);
  endtask

  task automatic t_lanes();
    logic [63:0] r1, r2;
    run_op(0, 0, 64'h7fff_0123_8000_0040, 64'h7fff_0001_ffff_0002);
    r1 = result_o;
    run_op(0, 0, 64'h0000_0123_8000_0040, 64'h0000_0001_ffff_0002);
    r2 = result_o;
    check("R1 other lanes unchanged", {16'h0, r2[47:0]}, {16'h0, r1[47:0]});
    check("R1 changed lane", {48'h0, r1[63:48]}, 64'h7fff);
    check("R1 cleared lane", {48'h0, r2[63:48]}, 64'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_signed();
    t_unsigned();
    t_avg();
    t_shift();
    t_unused();
    t_hold();
    t_lanes();
    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule